// File: doc/BRIEF.md
# Limit-Match Periodic Counter/Timer

This block is a word-addressed counter/timer. A count field advances by one unit on each pulse of a fixed-rate tick enable (one pulse every 500 ns in the intended system). The count is compared against a programmable limit. When the next count would equal a nonzero limit, the count returns to zero, a sticky reached flag is set and a level interrupt is raised. A limit of zero selects free-run: the count wraps at its all-ones field value and never raises the interrupt.

Software sees three word registers. The limit at offset 0 restarts the count when written and acknowledges the interrupt when read. The counter at offset 1 is read-only and shows the reached flag in bit 31. Offset 2 loads the limit without disturbing the running count. All accesses are full 32-bit words. Read data is registered and appears the cycle after the request.

Top module: `lim_timer`

## Requirements
- R1: After reset the limit, the count, the reached flag and irq_o are all zero, and the counter runs in free-run.
- R2: The count field occupies bits CNT_LSB+CNT_W-1..CNT_LSB (default 30..9). It rises by one on each cycle with tick_i high and is stable on cycles without tick_i. Bits CNT_LSB-1..0 always read as zero.
- R3: A read of offset 1 returns bit 31 as the reached flag and the count in its field. Every other bit is zero. The read has no side effect.
- R4: A write of offset 0 stores the write data's count field as the limit, clears irq_o and sets the count to zero. It takes priority over a tick in the same cycle, and that tick produces no match.
- R5: A write of offset 2 stores the limit field and leaves the count to advance as it would without the write. A match in that cycle is judged against the old limit.
- R6: With a nonzero limit, a tick whose next count equals the limit sets the count to zero, sets reached and drives irq_o high.
- R7: With a zero limit, a tick whose next count is the all-ones field value sets the count to zero, and neither reached nor irq_o is set.
- R8: A read of offset 0 returns the limit in its field, with all other bits zero. It clears reached and irq_o, unless a match occurs in the same cycle, in which case both end up set.
- R9: Writes to offsets 1 and 3 change nothing. Reads of offsets 2 and 3 return zero.
- R10: irq_o is a level that stays high until a read or write of offset 0. Whenever irq_o is high, reached is high.
- R11: If a limit loaded through offset 2 is not above the current count, the count runs on to the all-ones wrap, and the next arrival at the limit matches.
- R12: Read data appears on rdata_o in the cycle after the request and reflects the state before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Single-cycle count enable |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word offset (0 limit, 1 counter, 2 limit without restart, 3 unused) |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level interrupt on limit match |

## Verification
The assertions assume that req_i, we_i, addr_i and tick_i are settled and known at every rising edge after reset. They also assume that a tick and an offset-0 access may coincide, so the properties name which of the two wins. The bench drives every input on the falling edge and holds it for a full cycle. It sweeps every limit value of a 4-bit count field through both limit registers, using a tick pattern that leaves gaps. It places reads and ignored writes so that they fall on match cycles as well as on quiet ones.

// File: rtl/lim_timer_pkg.sv
package lim_timer_pkg;
  typedef enum logic [1:0] {
    OFF_LIMIT      = 2'd0,
    OFF_COUNT      = 2'd1,
    OFF_LIMIT_KEEP = 2'd2,
    OFF_RSVD       = 2'd3
  } reg_off_e;
endpackage

// File: rtl/lt_counter.sv
module lt_counter #(
  parameter int CNT_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             match_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MAX_F = '1;

  logic [CNT_W-1:0] cnt_q, nxt;
  logic             hit, wrap;

  assign nxt  = cnt_q + 1'b1;
  assign hit  = tick_i && (lim_i != '0) && (nxt == lim_i);
  assign wrap = tick_i && (nxt == MAX_F);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (restart_i)     cnt_q <= '0;
    else if (hit || wrap)   cnt_q <= '0;
    else if (tick_i)        cnt_q <= nxt;
  end

  assign match_o = hit && !restart_i;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/lt_limit_reg.sv
module lt_limit_reg #(
  parameter int DATA_W  = 32,
  parameter int CNT_LSB = 9,
  parameter int CNT_W   = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  lim_o
);
  logic [CNT_W-1:0] lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lim_q <= '0;
    else if (ld_i) lim_q <= wdata_i[CNT_LSB +: CNT_W];
  end

  assign lim_o = lim_q;
endmodule

// File: rtl/lt_flags.sv
module lt_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic ack_i,
  input  logic irq_clr_i,
  output logic reached_o,
  output logic irq_o
);
  logic reached_q, irq_q;

  // a match in the same cycle as an acknowledge wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (match_i)    reached_q <= 1'b1;
      else if (ack_i) reached_q <= 1'b0;
      if (match_i)                 irq_q <= 1'b1;
      else if (ack_i || irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign reached_o = reached_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/lt_rdata.sv
module lt_rdata
  import lim_timer_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_LSB = 9,
  parameter int CNT_W   = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  reg_off_e          off_i,
  input  logic [CNT_W-1:0]  lim_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              reached_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rd_d, rd_q;

  always_comb begin
    rd_d = '0;
    unique case (off_i)
      OFF_LIMIT: rd_d[CNT_LSB +: CNT_W] = lim_i;
      OFF_COUNT: begin
        rd_d[CNT_LSB +: CNT_W] = cnt_i;
        rd_d[DATA_W-1]         = reached_i;
      end
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (rd_i) rd_q <= rd_d;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/lim_timer.sv
module lim_timer
  import lim_timer_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_LSB = 9,
  parameter int CNT_W   = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  reg_off_e         off;
  logic             wr_lim, wr_keep, rd_lim, rd_any, lim_ld, match;
  logic [CNT_W-1:0] lim_q, cnt_q;
  logic             reached_q;

  assign off     = reg_off_e'(addr_i);
  assign wr_lim  = req_i && we_i && (off == OFF_LIMIT);
  assign wr_keep = req_i && we_i && (off == OFF_LIMIT_KEEP);
  assign rd_lim  = req_i && !we_i && (off == OFF_LIMIT);
  assign rd_any  = req_i && !we_i;
  assign lim_ld  = wr_lim || wr_keep;

  lt_limit_reg #(.DATA_W(DATA_W), .CNT_LSB(CNT_LSB), .CNT_W(CNT_W)) u_lim (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(lim_ld), .wdata_i(wdata_i), .lim_o(lim_q)
  );

  lt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .restart_i(wr_lim),
    .lim_i(lim_q), .match_o(match), .cnt_o(cnt_q)
  );

  lt_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .match_i(match), .ack_i(rd_lim),
    .irq_clr_i(wr_lim), .reached_o(reached_q), .irq_o(irq_o)
  );

  lt_rdata #(.DATA_W(DATA_W), .CNT_LSB(CNT_LSB), .CNT_W(CNT_W)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_any), .off_i(off), .lim_i(lim_q),
    .cnt_i(cnt_q), .reached_i(reached_q), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/lim_timer_chk.sv
module lim_timer_chk #(
  parameter int CNT_W = 22
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             req_i,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] lim,
  input logic             reached
);
  localparam logic [CNT_W-1:0] MAX_F = '1;
  logic acc0;
  assign acc0 = req_i && (addr_i == 2'd0);

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !(acc0 && we_i) |=> $stable(cnt)); // R2
  AST_WR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc0 && we_i |=> (cnt == '0) && !irq_o); // R4
  AST_FREE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim == '0) && !irq_o |=> !irq_o); // R7
  AST_CNT_NOT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt != MAX_F); // R7
  AST_RD_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc0 && !we_i && !tick_i |=> !irq_o && !reached); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !acc0 |=> irq_o); // R10
  AST_IRQ_REACHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> reached); // R10
  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (cnt == '0) && reached); // R6
endmodule

bind lim_timer lim_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .irq_o(irq_o), .cnt(cnt_q), .lim(lim_q), .reached(reached_q)
);

// File: tb/lim_timer_test.sv
module lim_timer_test;
  localparam int PERIOD  = 10;
  localparam int DATA_W  = 32;
  localparam int CNT_LSB = 9;
  localparam int CNT_W   = 4;
  localparam int MAXF    = (1 << CNT_W) - 1;

  logic              clk = 1'b0, rst_ni = 1'b0;
  logic              tick_i = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [1:0]        addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic              irq_o;

  int errors = 0, checks = 0;
  int m_cnt = 0, m_lim = 0, m_reached = 0, m_irq = 0;
  logic [DATA_W-1:0] exp_rd;

  always #(PERIOD/2) clk = ~clk;

  lim_timer #(.DATA_W(DATA_W), .CNT_LSB(CNT_LSB), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, model after posedge, check at next negedge
  task automatic step(input bit rq, input bit w, input int a, input int d, input bit tk, input string tag);
    int nxt;
    bit match;
    req_i = rq; we_i = w; addr_i = 2'(a); wdata_i = DATA_W'(d); tick_i = tk;
    @(posedge clk);
    exp_rd = '0;
    if (rq && !w && a == 0) exp_rd = DATA_W'(m_lim) << CNT_LSB;
    if (rq && !w && a == 1) exp_rd = (DATA_W'(m_reached) << (DATA_W-1)) | (DATA_W'(m_cnt) << CNT_LSB);
    match = 1'b0;
    if (rq && w && a == 0) m_cnt = 0;
    else if (tk) begin
      nxt = m_cnt + 1;
      if (m_lim != 0 && nxt == m_lim) begin m_cnt = 0; match = 1'b1; end
      else if (nxt == MAXF) m_cnt = 0;
      else m_cnt = nxt;
    end
    if (match) begin m_reached = 1; m_irq = 1; end
    else begin
      if (rq && !w && a == 0) begin m_reached = 0; m_irq = 0; end
      if (rq && w && a == 0) m_irq = 0;
    end
    if (rq && w && (a == 0 || a == 2)) m_lim = (d >> CNT_LSB) & MAXF;
    @(negedge clk);
    req_i = 1'b0; tick_i = 1'b0;
    chk({tag, " irq (R6 R10)"}, DATA_W'(irq_o), DATA_W'(m_irq));
    if (rq && !w) chk({tag, " rdata (R12)"}, rdata_o, exp_rd);
  endtask

  initial begin : watchdog
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", DATA_W'(irq_o), '0);
    step(1, 0, 0, 0, 0, "R1 lim");
    step(1, 0, 1, 0, 0, "R1 cnt");
    // R7 free-run wrap, R2 stepping and holding
    for (int i = 0; i < 2 * MAXF + 3; i++) step(1, 0, 1, 0, (i % 3) != 2, "R2 R7 R3");
    // R11: count at 10 then a lower limit through offset 2
    step(1, 1, 0, 0, 0, "R4");
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 1, "R2");
    step(1, 1, 2, 4 << CNT_LSB, 1, "R5 R11");
    for (int i = 0; i < 12; i++) step(1, 0, 1, 0, 1, "R11");
    // R9 ignored writes and reserved reads
    step(1, 1, 1, 32'h7FFF_FFFF, 1, "R9");
    step(1, 1, 3, 32'h7FFF_FFFF, 1, "R9");
    step(1, 0, 2, 0, 0, "R9");
    step(1, 0, 3, 0, 0, "R9");
    step(1, 0, 0, 0, 0, "R9 R8");
    // sweep of every limit through both load offsets
    for (int mode = 0; mode < 2; mode++) begin
      for (int l = 0; l <= MAXF; l++) begin
        step(1, 1, mode ? 2 : 0, (l << CNT_LSB) | 32'h1FF | (mode << 31), l[0], "R4 R5");
        for (int i = 0; i < 40; i++) begin
          bit tk = (i % 4) != 3;
          if (i % 5 == 0)       step(1, 0, 1, 0, tk, "R3");
          else if (i % 13 == 0) step(1, 0, 0, 0, tk, "R8");
          else if (i % 11 == 0) step(1, 1, 1, 32'h5555_5555, tk, "R9");
          else if (i == 37)     step(1, 1, 0, l << CNT_LSB, 1, "R4 prio");
          else                  step(0, 0, 0, 0, tk, "R6 R7");
        end
        step(1, 0, 1, 0, 0, "R3 R6");
      end
    end
    // R8 match coinciding with acknowledge: limit 2, count 1
    step(1, 1, 0, 2 << CNT_LSB, 0, "R4");
    step(0, 0, 0, 0, 1, "R2");
    step(1, 0, 0, 0, 1, "R8 coincide");
    step(1, 0, 1, 0, 0, "R8 reached kept");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule